// File: doc/BRIEF.md
# PCIe Root-Port Power-Up Sequencer

This block is a hardware state machine that takes a PCIe root port from a cold, reset-held condition to a configured, PHY-ready state in one fixed order. It controls the slot power switch, the controller-side fundamental reset and the slot-side fundamental reset line. It also drives an auxiliary clock enable, a hold-PHY-reset output, the controller power-up reset release, the per-PHY configuration select lines and the device-type value. Wait times come from a millisecond tick input and from a cycle count.

Once the PHYs are selected, the sequencer sends eight PHY configuration writes through a simple request port. It goes lane by lane over the first PHY and then over the second. It waits for a done or timeout response to each write before moving on. After the last write it gates the auxiliary clock off, clears the PHY hold, turns the clock back on and sets the device type to root complex. It marks that point with a one-cycle done pulse. A start pulse restarts the whole sequence from reset assertion in any state. A shutdown pulse drops the port back to the fully reset, unpowered state.

Each step occupies its own state, and all outputs are decoded from the state register. The state names, in sequence order, are: OFF, ASSERT, PWR_WAIT, REL_CTRL, REL_SLOT, AUX_ON, HOLD_ON, PWRUP, SEL_WAIT, WR_ISSUE, WR_GAP, AUX_OFF, HOLD_CLR, AUX_REON, DEVTYPE and UP. Each state advances to the next one in that order, with these exceptions:
- PWR_WAIT leaves once PERST_MS ticks have been counted.
- SEL_WAIT leaves once SEL_WAIT cycles have been counted.
- WR_ISSUE moves on a response, to WR_GAP, or to AUX_OFF after the last write.
- WR_GAP returns to WR_ISSUE.
- OFF and UP hold their state.
- Shutdown takes any state to OFF, and start takes any state to ASSERT.

Top module: `brs_seq_top`

## Requirements
- R1: After rst_n, the block sits in OFF and waits for start_i. In OFF, both reset outputs are low, slot power is off and the auxiliary clock is off. Hold, power-up release, PHY select, write request, done and warning are all 0, and dev_type_o is 0.
- R2: On start_i, the block first spends one cycle with both resets low and power off. It then raises slot_pwr_en_o while keeping both resets low. The resets stay low until PERST_MS millisecond ticks have been counted inside that wait. Ticks seen outside the wait are ignored. ctrl_rst_n_o goes high in the cycle after the last tick is counted, and slot_rst_n_o goes high one cycle later.
- R3: The next three steps come one per cycle, in this order: aux_clk_en_o rises, then hold_phy_rst_o rises, then pwrup_rst_n_o rises.
- R4: One cycle after the power-up release, every bit of phy_sel_o is set. The first write request appears exactly SEL_WAIT+1 cycles after that.
- R5: Exactly eight writes are issued. The first four go to PHY 0 lanes 0 to 3, and the next four go to PHY 1 lanes 0 to 3. wr_phy_o carries the PHY number, and wr_addr_o is 0x1008 + 0x100 × lane. Every write happens while hold, power-up release and the auxiliary clock are all active.
- R6: Every write carries wr_data_o = 0x0E21, which has bits 0, 5, 9, 10 and 11 set. wr_req_o stays high with stable fields until wr_done_i or wr_timeout_i is sampled high. It is then low for exactly one cycle before the next write.
- R7: After the response to the last write, the closing steps come one per cycle. First the auxiliary clock turns off while hold stays high. Next hold clears. Then the auxiliary clock turns back on. Finally dev_type_o becomes 4 and seq_done_o pulses for exactly one cycle. The block then stays in UP with dev_type_o at 4.
- R8: A timeout response sets warn_o, and the sequence continues with the next write. warn_o stays set until the next start_i. Responses that arrive while no write is pending are ignored and do not move the write sequence.
- R9: shutdown_i sends the block to OFF at the next clock edge from any state, and it takes priority over start_i.
- R10: start_i in any state other than a shutdown cycle restarts the sequence at ASSERT at the next edge. The restart drops power, dev_type_o and warn_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start or restart the bring-up sequence |
| shutdown_i | input | 1 | Return to the reset-held, unpowered state |
| ms_tick_i | input | 1 | One-cycle pulse each millisecond |
| wr_done_i | input | 1 | PHY write completed |
| wr_timeout_i | input | 1 | PHY write timed out |
| ctrl_rst_n_o | output | 1 | Controller-side fundamental reset, active low |
| slot_rst_n_o | output | 1 | Slot fundamental reset line, active low |
| slot_pwr_en_o | output | 1 | Slot power enable |
| aux_clk_en_o | output | 1 | Auxiliary clock enable |
| hold_phy_rst_o | output | 1 | Hold link state machine and PHY in reset |
| pwrup_rst_n_o | output | 1 | Controller power-up reset release |
| phy_sel_o | output | N_PHY | PHY configuration port select, one bit per PHY |
| dev_type_o | output | DEVTYPE_W | Device type value, 4 = root complex |
| wr_req_o | output | 1 | PHY write request |
| wr_phy_o | output | PHY_W | PHY targeted by the write |
| wr_addr_o | output | ADDR_W | PHY register address |
| wr_data_o | output | DATA_W | PHY register data |
| seq_done_o | output | 1 | One-cycle pulse when the device type is set |
| warn_o | output | 1 | Sticky flag, set when a write times out |

## Verification
All outputs are decoded from the state register, so an input sampled at an edge affects the outputs in the cycle right after that edge. Each later step adds exactly one cycle. For example, the slot release comes two cycles after the last counted tick, the first write comes SEL_WAIT+1 cycles after select, and done comes four cycles after the last write response. The bench drives inputs and samples outputs 1 ns after the rising edge. It advances exactly one clock between samples, so every check lands on the single cycle in which a step is due. It never uses a wait-until loop, except when counting the select-to-write gap, and that count is itself compared exactly.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic [3:0] {
        S_OFF,
        S_ASSERT,
        S_PWR_WAIT,
        S_REL_CTRL,
        S_REL_SLOT,
        S_AUX_ON,
        S_HOLD_ON,
        S_PWRUP,
        S_SEL_WAIT,
        S_WR_ISSUE,
        S_WR_GAP,
        S_AUX_OFF,
        S_HOLD_CLR,
        S_AUX_REON,
        S_DEVTYPE,
        S_UP
    } brs_state_e;

    // PHY receive override value: CDR tracking (0), LOS threshold (5),
    // termination enable (9), AC termination (10), PHY enable (11)
    localparam logic [15:0] BRS_PHY_CFG = 16'((1 << 0) | (1 << 5) | (1 << 9) | (1 << 10) | (1 << 11));

    localparam logic [15:0] BRS_LANE_BASE   = 16'h1008;
    localparam logic [15:0] BRS_LANE_STRIDE = 16'h0100;

endpackage

// File: rtl/brs_wait_cnt.sv
module brs_wait_cnt #(
    parameter int LIMIT = 10,
    localparam int CNT_W = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic reached
);

    logic [CNT_W-1:0] cnt;

    assign reached = (cnt >= CNT_W'(LIMIT));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && !reached) begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/brs_wr_seq.sv
module brs_wr_seq #(
    parameter int N_PHY  = 2,
    parameter int N_LANE = 4,
    parameter int ADDR_W = 16,
    parameter int PHY_W  = 1,
    parameter logic [ADDR_W-1:0] BASE   = ADDR_W'(16'h1008),
    parameter logic [ADDR_W-1:0] STRIDE = ADDR_W'(16'h0100),
    localparam int N_WR   = N_PHY * N_LANE,
    localparam int IDX_W  = (N_WR > 1) ? $clog2(N_WR) : 1,
    localparam int LANE_W = (N_LANE > 1) ? $clog2(N_LANE) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [PHY_W-1:0]  phy_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);

    logic [IDX_W-1:0]  idx;
    logic [LANE_W-1:0] lane;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx <= '0;
        end else if (clr) begin
            idx <= '0;
        end else if (adv && !last_o) begin
            idx <= idx + 1'b1;
        end
    end

    assign last_o = (idx == IDX_W'(N_WR - 1));

    generate
        if (N_LANE > 1 && (1 << LANE_W) == N_LANE && IDX_W > LANE_W) begin : g_pow2
            assign lane  = idx[LANE_W-1:0];
            assign phy_o = PHY_W'(idx >> LANE_W);
        end else begin : g_div
            assign lane  = LANE_W'(idx % IDX_W'(N_LANE));
            assign phy_o = PHY_W'(idx / IDX_W'(N_LANE));
        end
    endgenerate

    assign addr_o = BASE + ADDR_W'(lane) * STRIDE;

endmodule

// File: rtl/brs_seq_top.sv
module brs_seq_top
    import brs_pkg::*;
#(
    parameter int N_PHY      = 2,
    parameter int N_LANE     = 4,
    parameter int PERST_MS   = 100,
    parameter int SEL_WAIT   = 10,
    parameter int ADDR_W     = 16,
    parameter int DATA_W     = 16,
    parameter int DEVTYPE_W  = 4,
    parameter int DEVTYPE_RC = 4,
    localparam int PHY_W = (N_PHY > 1) ? $clog2(N_PHY) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic                 shutdown_i,
    input  logic                 ms_tick_i,
    input  logic                 wr_done_i,
    input  logic                 wr_timeout_i,
    output logic                 ctrl_rst_n_o,
    output logic                 slot_rst_n_o,
    output logic                 slot_pwr_en_o,
    output logic                 aux_clk_en_o,
    output logic                 hold_phy_rst_o,
    output logic                 pwrup_rst_n_o,
    output logic [N_PHY-1:0]     phy_sel_o,
    output logic [DEVTYPE_W-1:0] dev_type_o,
    output logic                 wr_req_o,
    output logic [PHY_W-1:0]     wr_phy_o,
    output logic [ADDR_W-1:0]    wr_addr_o,
    output logic [DATA_W-1:0]    wr_data_o,
    output logic                 seq_done_o,
    output logic                 warn_o
);

    brs_state_e st, nxt;
    logic       ms_reached, sel_reached, wr_last, rsp;

    assign rsp = wr_done_i | wr_timeout_i;

    brs_wait_cnt #(.LIMIT(PERST_MS)) u_ms_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (st != S_PWR_WAIT),
        .inc     (ms_tick_i),
        .reached (ms_reached)
    );

    brs_wait_cnt #(.LIMIT(SEL_WAIT)) u_sel_wait (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (st != S_SEL_WAIT),
        .inc     (1'b1),
        .reached (sel_reached)
    );

    brs_wr_seq #(
        .N_PHY  (N_PHY),
        .N_LANE (N_LANE),
        .ADDR_W (ADDR_W),
        .PHY_W  (PHY_W),
        .BASE   (ADDR_W'(BRS_LANE_BASE)),
        .STRIDE (ADDR_W'(BRS_LANE_STRIDE))
    ) u_wr_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    ((st != S_WR_ISSUE) && (st != S_WR_GAP)),
        .adv    ((st == S_WR_ISSUE) && rsp),
        .phy_o  (wr_phy_o),
        .addr_o (wr_addr_o),
        .last_o (wr_last)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= S_OFF;
        end else begin
            st <= nxt;
        end
    end

    // sticky timeout flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warn_o <= 1'b0;
        end else if (start_i && !shutdown_i) begin
            warn_o <= 1'b0;
        end else if ((st == S_WR_ISSUE) && wr_timeout_i) begin
            warn_o <= 1'b1;
        end
    end

    // next state
    always_comb begin
        nxt = st;
        if (shutdown_i) begin
            nxt = S_OFF;
        end else if (start_i) begin
            nxt = S_ASSERT;
        end else begin
            unique case (st)
                S_OFF:      nxt = S_OFF;
                S_ASSERT:   nxt = S_PWR_WAIT;
                S_PWR_WAIT: if (ms_reached) nxt = S_REL_CTRL;
                S_REL_CTRL: nxt = S_REL_SLOT;
                S_REL_SLOT: nxt = S_AUX_ON;
                S_AUX_ON:   nxt = S_HOLD_ON;
                S_HOLD_ON:  nxt = S_PWRUP;
                S_PWRUP:    nxt = S_SEL_WAIT;
                S_SEL_WAIT: if (sel_reached) nxt = S_WR_ISSUE;
                S_WR_ISSUE: if (rsp) nxt = wr_last ? S_AUX_OFF : S_WR_GAP;
                S_WR_GAP:   nxt = S_WR_ISSUE;
                S_AUX_OFF:  nxt = S_HOLD_CLR;
                S_HOLD_CLR: nxt = S_AUX_REON;
                S_AUX_REON: nxt = S_DEVTYPE;
                S_DEVTYPE:  nxt = S_UP;
                S_UP:       nxt = S_UP;
                default:    nxt = S_OFF;
            endcase
        end
    end

    // outputs decoded from state
    always_comb begin
        ctrl_rst_n_o   = 1'b0;
        slot_rst_n_o   = 1'b0;
        slot_pwr_en_o  = 1'b0;
        aux_clk_en_o   = 1'b0;
        hold_phy_rst_o = 1'b0;
        pwrup_rst_n_o  = 1'b0;
        phy_sel_o      = '0;
        dev_type_o     = '0;
        wr_req_o       = 1'b0;
        seq_done_o     = 1'b0;
        unique case (st)
            S_OFF, S_ASSERT: begin
            end
            S_PWR_WAIT: begin
                slot_pwr_en_o = 1'b1;
            end
            S_REL_CTRL: begin
                slot_pwr_en_o = 1'b1;
                ctrl_rst_n_o  = 1'b1;
            end
            S_REL_SLOT: begin
                slot_pwr_en_o = 1'b1;
                ctrl_rst_n_o  = 1'b1;
                slot_rst_n_o  = 1'b1;
            end
            S_AUX_ON: begin
                slot_pwr_en_o = 1'b1;
                ctrl_rst_n_o  = 1'b1;
                slot_rst_n_o  = 1'b1;
                aux_clk_en_o  = 1'b1;
            end
            S_HOLD_ON: begin
                slot_pwr_en_o  = 1'b1;
                ctrl_rst_n_o   = 1'b1;
                slot_rst_n_o   = 1'b1;
                aux_clk_en_o   = 1'b1;
                hold_phy_rst_o = 1'b1;
            end
            S_PWRUP: begin
                slot_pwr_en_o  = 1'b1;
                ctrl_rst_n_o   = 1'b1;
                slot_rst_n_o   = 1'b1;
                aux_clk_en_o   = 1'b1;
                hold_phy_rst_o = 1'b1;
                pwrup_rst_n_o  = 1'b1;
            end
            S_SEL_WAIT, S_WR_GAP: begin
                slot_pwr_en_o  = 1'b1;
                ctrl_rst_n_o   = 1'b1;
                slot_rst_n_o   = 1'b1;
                aux_clk_en_o   = 1'b1;
                hold_phy_rst_o = 1'b1;
                pwrup_rst_n_o  = 1'b1;
                phy_sel_o      = '1;
            end
            S_WR_ISSUE: begin
                slot_pwr_en_o  = 1'b1;
                ctrl_rst_n_o   = 1'b1;
                slot_rst_n_o   = 1'b1;
                aux_clk_en_o   = 1'b1;
                hold_phy_rst_o = 1'b1;
                pwrup_rst_n_o  = 1'b1;
                phy_sel_o      = '1;
                wr_req_o       = 1'b1;
            end
            S_AUX_OFF: begin
                slot_pwr_en_o  = 1'b1;
                ctrl_rst_n_o   = 1'b1;
                slot_rst_n_o   = 1'b1;
                hold_phy_rst_o = 1'b1;
                pwrup_rst_n_o  = 1'b1;
                phy_sel_o      = '1;
            end
            S_HOLD_CLR: begin
                slot_pwr_en_o = 1'b1;
                ctrl_rst_n_o  = 1'b1;
                slot_rst_n_o  = 1'b1;
                pwrup_rst_n_o = 1'b1;
                phy_sel_o     = '1;
            end
            S_AUX_REON: begin
                slot_pwr_en_o = 1'b1;
                ctrl_rst_n_o  = 1'b1;
                slot_rst_n_o  = 1'b1;
                aux_clk_en_o  = 1'b1;
                pwrup_rst_n_o = 1'b1;
                phy_sel_o     = '1;
            end
            S_DEVTYPE, S_UP: begin
                slot_pwr_en_o = 1'b1;
                ctrl_rst_n_o  = 1'b1;
                slot_rst_n_o  = 1'b1;
                aux_clk_en_o  = 1'b1;
                pwrup_rst_n_o = 1'b1;
                phy_sel_o     = '1;
                dev_type_o    = DEVTYPE_W'(DEVTYPE_RC);
                seq_done_o    = (st == S_DEVTYPE);
            end
            default: begin
            end
        endcase
    end

    assign wr_data_o = DATA_W'(BRS_PHY_CFG);

endmodule

// File: rtl/brs_chk.sv
module brs_chk #(
    parameter int N_PHY      = 2,
    parameter int PERST_MS   = 100,
    parameter int SEL_WAIT   = 10,
    parameter int PHY_W      = 1,
    parameter int ADDR_W     = 16,
    parameter int DEVTYPE_W  = 4,
    parameter int DEVTYPE_RC = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start_i,
    input logic                 shutdown_i,
    input logic                 ms_tick_i,
    input logic                 wr_done_i,
    input logic                 wr_timeout_i,
    input logic                 ctrl_rst_n_o,
    input logic                 slot_rst_n_o,
    input logic                 slot_pwr_en_o,
    input logic                 aux_clk_en_o,
    input logic                 hold_phy_rst_o,
    input logic                 pwrup_rst_n_o,
    input logic [N_PHY-1:0]     phy_sel_o,
    input logic [DEVTYPE_W-1:0] dev_type_o,
    input logic                 wr_req_o,
    input logic [PHY_W-1:0]     wr_phy_o,
    input logic [ADDR_W-1:0]    wr_addr_o,
    input logic                 seq_done_o,
    input logic                 warn_o
);

    logic [15:0] pwr_ticks;
    logic [15:0] sel_cycles;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pwr_ticks <= '0;
        end else if (!slot_pwr_en_o) begin
            pwr_ticks <= '0;
        end else if (!ctrl_rst_n_o && ms_tick_i && pwr_ticks != 16'hFFFF) begin
            pwr_ticks <= pwr_ticks + 16'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_cycles <= '0;
        end else if (phy_sel_o == '0) begin
            sel_cycles <= '0;
        end else if (sel_cycles != 16'hFFFF) begin
            sel_cycles <= sel_cycles + 16'd1;
        end
    end

    AST_RST_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        slot_rst_n_o |-> ctrl_rst_n_o); // R2

    AST_PERST_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_rst_n_o) |-> (pwr_ticks >= 16'(PERST_MS))); // R2

    AST_PWRUP_PREREQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwrup_rst_n_o) |-> (aux_clk_en_o && hold_phy_rst_o && slot_rst_n_o)); // R3

    AST_SEL_SETTLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_req_o) |-> (sel_cycles >= 16'(SEL_WAIT))); // R4

    AST_WR_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> (hold_phy_rst_o && pwrup_rst_n_o && aux_clk_en_o)); // R5

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req_o && !wr_done_i && !wr_timeout_i && !start_i && !shutdown_i)
        |=> (wr_req_o && $stable(wr_addr_o) && $stable(wr_phy_o))); // R6

    AST_HOLD_CLR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(hold_phy_rst_o) && pwrup_rst_n_o) |-> !aux_clk_en_o); // R7

    AST_DONE_RC: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |-> (dev_type_o == DEVTYPE_W'(DEVTYPE_RC) && !hold_phy_rst_o)); // R7

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |=> !seq_done_o); // R7

    AST_WARN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_o && !start_i) |=> warn_o); // R8

    AST_SHUTDOWN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown_i |=> (!ctrl_rst_n_o && !slot_rst_n_o && !slot_pwr_en_o && !aux_clk_en_o)); // R9

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !shutdown_i) |=> (!warn_o && !slot_pwr_en_o && !ctrl_rst_n_o)); // R10

endmodule

bind brs_seq_top brs_chk #(
    .N_PHY      (N_PHY),
    .PERST_MS   (PERST_MS),
    .SEL_WAIT   (SEL_WAIT),
    .PHY_W      (PHY_W),
    .ADDR_W     (ADDR_W),
    .DEVTYPE_W  (DEVTYPE_W),
    .DEVTYPE_RC (DEVTYPE_RC)
) u_brs_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_i        (start_i),
    .shutdown_i     (shutdown_i),
    .ms_tick_i      (ms_tick_i),
    .wr_done_i      (wr_done_i),
    .wr_timeout_i   (wr_timeout_i),
    .ctrl_rst_n_o   (ctrl_rst_n_o),
    .slot_rst_n_o   (slot_rst_n_o),
    .slot_pwr_en_o  (slot_pwr_en_o),
    .aux_clk_en_o   (aux_clk_en_o),
    .hold_phy_rst_o (hold_phy_rst_o),
    .pwrup_rst_n_o  (pwrup_rst_n_o),
    .phy_sel_o      (phy_sel_o),
    .dev_type_o     (dev_type_o),
    .wr_req_o       (wr_req_o),
    .wr_phy_o       (wr_phy_o),
    .wr_addr_o      (wr_addr_o),
    .seq_done_o     (seq_done_o),
    .warn_o         (warn_o)
);

// File: tb/tb_brs_seq_top.sv
`timescale 1ns/1ps
module tb_brs_seq_top;

    localparam int N_PHY    = 2;
    localparam int N_LANE   = 4;
    localparam int PERST_MS = 100;
    localparam int SEL_WAIT = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        shutdown_i = 1'b0;
    logic        ms_tick_i = 1'b0;
    logic        wr_done_i = 1'b0;
    logic        wr_timeout_i = 1'b0;
    logic        ctrl_rst_n_o, slot_rst_n_o, slot_pwr_en_o, aux_clk_en_o;
    logic        hold_phy_rst_o, pwrup_rst_n_o, wr_req_o, seq_done_o, warn_o;
    logic [1:0]  phy_sel_o;
    logic [3:0]  dev_type_o;
    logic [0:0]  wr_phy_o;
    logic [15:0] wr_addr_o, wr_data_o;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    brs_seq_top #(
        .N_PHY    (N_PHY),
        .N_LANE   (N_LANE),
        .PERST_MS (PERST_MS),
        .SEL_WAIT (SEL_WAIT)
    ) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .shutdown_i     (shutdown_i),
        .ms_tick_i      (ms_tick_i),
        .wr_done_i      (wr_done_i),
        .wr_timeout_i   (wr_timeout_i),
        .ctrl_rst_n_o   (ctrl_rst_n_o),
        .slot_rst_n_o   (slot_rst_n_o),
        .slot_pwr_en_o  (slot_pwr_en_o),
        .aux_clk_en_o   (aux_clk_en_o),
        .hold_phy_rst_o (hold_phy_rst_o),
        .pwrup_rst_n_o  (pwrup_rst_n_o),
        .phy_sel_o      (phy_sel_o),
        .dev_type_o     (dev_type_o),
        .wr_req_o       (wr_req_o),
        .wr_phy_o       (wr_phy_o),
        .wr_addr_o      (wr_addr_o),
        .wr_data_o      (wr_data_o),
        .seq_done_o     (seq_done_o),
        .warn_o         (warn_o)
    );

    always #2.5 clk = ~clk;

    task automatic chk_eq(input string req, input string what,
                          input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) cyc();
        rst_n = 1'b1;
        cyc();
        // R1: off state
        chk_eq("R1", "ctrl_rst_n", 32'(ctrl_rst_n_o), 0);
        chk_eq("R1", "slot_rst_n", 32'(slot_rst_n_o), 0);
        chk_eq("R1", "slot_pwr", 32'(slot_pwr_en_o), 0);
        chk_eq("R1", "aux/hold/pwrup/sel/req/done/warn",
               32'({aux_clk_en_o, hold_phy_rst_o, pwrup_rst_n_o, phy_sel_o,
                    wr_req_o, seq_done_o, warn_o}), 0);
        chk_eq("R1", "dev_type", 32'(dev_type_o), 0);
        // R2: ticks before start do nothing
        for (int i = 0; i < 3; i++) begin
            ms_tick_i = 1'b1;
            cyc();
            ms_tick_i = 1'b0;
        end
        cyc();
        chk_eq("R2", "no power without start", 32'(slot_pwr_en_o), 0);
    endtask

    task automatic bringup(input int tmo_idx, input bit stray);
        bit early;
        int n;
        logic [15:0] held_addr;
        start_i = 1'b1;
        cyc();
        start_i = 1'b0;
        chk_eq("R10", "resets low after start", 32'({ctrl_rst_n_o, slot_rst_n_o}), 0);
        chk_eq("R10", "power off in assert step", 32'(slot_pwr_en_o), 0);
        chk_eq("R10", "dev_type cleared", 32'(dev_type_o), 0);
        chk_eq("R8", "warn cleared by start", 32'(warn_o), 0);
        cyc();
        chk_eq("R2", "power on, resets held", 32'({slot_pwr_en_o, ctrl_rst_n_o, slot_rst_n_o}), 32'b100);
        early = 1'b0;
        for (int i = 0; i < PERST_MS; i++) begin
            ms_tick_i = 1'b1;
            cyc();
            ms_tick_i = 1'b0;
            if (ctrl_rst_n_o) early = 1'b1;
            cyc();
            if (i < PERST_MS - 1 && ctrl_rst_n_o) early = 1'b1;
        end
        chk_eq("R2", "reset held for full tick count", 32'(early), 0);
        chk_eq("R2", "ctrl released first", 32'({ctrl_rst_n_o, slot_rst_n_o}), 32'b10);
        cyc();
        chk_eq("R2", "slot released next", 32'({slot_rst_n_o, aux_clk_en_o}), 32'b10);
        cyc();
        chk_eq("R3", "aux on", 32'({aux_clk_en_o, hold_phy_rst_o}), 32'b10);
        cyc();
        chk_eq("R3", "hold on", 32'({hold_phy_rst_o, pwrup_rst_n_o}), 32'b10);
        cyc();
        chk_eq("R3", "pwrup released", 32'({pwrup_rst_n_o, phy_sel_o}), 32'b100);
        cyc();
        chk_eq("R4", "phy select all", 32'(phy_sel_o), 32'b11);
        n = 0;
        while (!wr_req_o && n < 100) begin
            if (stray && n == 2) begin
                wr_done_i = 1'b1;
                wr_timeout_i = 1'b1;
            end
            cyc();
            wr_done_i = 1'b0;
            wr_timeout_i = 1'b0;
            n++;
        end
        chk_eq("R4", "select to first write cycles", 32'(n), 32'(SEL_WAIT + 1));
        if (stray) chk_eq("R8", "stray response ignored", 32'(warn_o), 0);
        for (int k = 0; k < N_PHY * N_LANE; k++) begin
            chk_eq("R5", "request present", 32'(wr_req_o), 1);
            chk_eq("R5", "phy index", 32'(wr_phy_o), 32'(k / N_LANE));
            chk_eq("R5", "lane address", 32'(wr_addr_o), 32'(16'h1008 + 16'h0100 * (k % N_LANE)));
            chk_eq("R6", "write data", 32'(wr_data_o), 32'h0E21);
            held_addr = wr_addr_o;
            for (int d = 0; d < k % 3; d++) begin
                cyc();
                chk_eq("R6", "request held with stable address",
                       32'({wr_req_o, wr_addr_o}), 32'({1'b1, held_addr}));
            end
            wr_done_i = (k != tmo_idx);
            wr_timeout_i = (k == tmo_idx);
            cyc();
            wr_done_i = 1'b0;
            wr_timeout_i = 1'b0;
            if (k == tmo_idx) chk_eq("R8", "warn after timeout", 32'(warn_o), 1);
            if (k < N_PHY * N_LANE - 1) begin
                chk_eq("R6", "idle cycle between writes", 32'(wr_req_o), 0);
                cyc();
            end
        end
        chk_eq("R7", "aux gated, hold kept", 32'({wr_req_o, aux_clk_en_o, hold_phy_rst_o}), 32'b001);
        cyc();
        chk_eq("R7", "hold cleared, aux still off", 32'({aux_clk_en_o, hold_phy_rst_o, pwrup_rst_n_o}), 32'b001);
        cyc();
        chk_eq("R7", "aux back on, no type yet", 32'({aux_clk_en_o, seq_done_o, dev_type_o}), 32'b1_0_0000);
        cyc();
        chk_eq("R7", "type set with done", 32'({seq_done_o, dev_type_o}), 32'b1_0100);
        cyc();
        chk_eq("R7", "steady up", 32'({seq_done_o, dev_type_o, aux_clk_en_o, slot_pwr_en_o}), 32'b0_0100_1_1);
        chk_eq("R8", "warn final", 32'(warn_o), 32'(tmo_idx >= 0));
    endtask

    task automatic t_shutdown_early();
        start_i = 1'b1;
        cyc();
        start_i = 1'b0;
        cyc();
        chk_eq("R9", "in power wait", 32'(slot_pwr_en_o), 1);
        shutdown_i = 1'b1;
        start_i = 1'b1;
        cyc();
        shutdown_i = 1'b0;
        start_i = 1'b0;
        chk_eq("R9", "off after shutdown", 32'({slot_pwr_en_o, ctrl_rst_n_o, slot_rst_n_o}), 0);
        repeat (3) cyc();
        chk_eq("R9", "shutdown beats start", 32'(slot_pwr_en_o), 0);
    endtask

    task automatic t_shutdown_up();
        shutdown_i = 1'b1;
        cyc();
        shutdown_i = 1'b0;
        chk_eq("R9", "off from up",
               32'({ctrl_rst_n_o, slot_rst_n_o, slot_pwr_en_o, aux_clk_en_o, pwrup_rst_n_o, phy_sel_o, dev_type_o}), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        bringup(-1, 1'b1);
        bringup(3, 1'b0);
        bringup(-1, 1'b0);
        t_shutdown_up();
        t_shutdown_early();
        bringup(7, 1'b0);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule